// File: doc/BRIEF.md
# Multi-drop serial receiver with address filtering

This block is an asynchronous serial receiver for a shared bus with one master and several listening nodes. Each frame carries a frame-type marker. A marker of one means an address frame and zero means a data frame. When the host sets the filter input, the receiver discards data frames in hardware. Only address frames reach the receive holding register. The host reads each address. If the address matches, the host clears the filter so that the data frames that follow are delivered. When the transfer ends, the host sets the filter again.

Character size can be 5 to 9 data bits. With nine bits, the ninth data bit is the marker. With 5 to 8 bits, the first stop bit is the marker and a second stop bit ends the frame. The line is oversampled by a 16x tick enable supplied from outside. A start bit begins on a falling edge and must still be low at half a bit time. Every later bit is sampled once at its middle. The holding register presents the byte, the marker, a framing-error flag and an overrun flag. A completion flag stays set until the host pulses a read strobe.

Top module: `mdrop_uart_rx`

## Requirements
- R1: A start bit is recognised only on a high-to-low transition of the line, and only if the line is still low after 8 tick enables. A low pulse that is back high by then produces no frame.
- R2: Data bits are taken least significant first, one sample per 16 ticks at mid-bit. A size of N bits (N = 5..8) fills rx_data[N-1:0] and leaves the upper bits zero. A size input below 5 acts as 5 and a size above 9 acts as 9.
- R3: With a size of 9, rx_data holds data bits 0..7 and rx_type holds data bit 8. One stop bit follows.
- R4: With a size of 5 to 8, the first stop bit is presented on rx_type and a second stop bit follows it.
- R5: While filter_en is high, a frame whose marker is 0 is discarded. rx_valid, rx_data, rx_type, rx_ferr and rx_ovr are left unchanged.
- R6: A frame whose marker is 1 is always accepted: rx_valid is set and rx_type reads 1, whatever filter_en holds.
- R7: While filter_en is low, every frame is accepted, including frames whose marker is 0.
- R8: rx_ferr is stored with each accepted frame and is 1 exactly when the last stop bit was sampled low. A low first stop bit in 5 to 8 bit mode is never a framing error.
- R9: If a frame is accepted while rx_valid is set and no read is pulsed, rx_ovr is set and the held byte is kept. A pulse on rd_strobe clears both rx_valid and rx_ovr.
- R10: filter_en is evaluated when the last stop bit of a frame is sampled, so a change made in the middle of a frame applies to that frame.
- R11: After reset, rx_valid, rx_ovr, rx_ferr, rx_type and rx_data are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_in | input | 1 | Serial line, idle high |
| os_tick | input | 1 | Enable pulse at 16 times the bit rate |
| char_bits | input | 4 | Data bits per character, 5 to 9 |
| filter_en | input | 1 | Set to discard data frames |
| rd_strobe | input | 1 | One-cycle read pulse that clears rx_valid and rx_ovr |
| rx_data | output | 8 | Received data, low eight bits |
| rx_type | output | 1 | Frame-type marker of the held frame (1 = address) |
| rx_valid | output | 1 | Holding register contains an unread frame |
| rx_ferr | output | 1 | Held frame ended with a low last stop bit |
| rx_ovr | output | 1 | An accepted frame was lost because the register was full |

## Verification
A wrong bit index or a wrong marker position shows up at the ports when the very frame it affects completes. The result is a shifted byte, a wrong rx_type, or a data frame that passes the filter or is dropped when it should not be. A counter that drifts out of step with the bit time gives a wrong value at a later bit, or a frame that never completes, visible about two bit times after the stop bit. Overrun and filter-timing faults only appear in certain orders of frames and reads. The bench therefore mixes random sizes, markers, filter settings and read patterns with directed mid-frame filter changes and runt start pulses.

// File: rtl/mdrop_uart_rx.sv
module mdrop_uart_rx #(
  parameter int OSR  = 16,
  parameter int HALF = OSR / 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_in,
  input  logic       os_tick,
  input  logic [3:0] char_bits,
  input  logic       filter_en,
  input  logic       rd_strobe,
  output logic [7:0] rx_data,
  output logic       rx_type,
  output logic       rx_valid,
  output logic       rx_ferr,
  output logic       rx_ovr
);
  localparam int CW = $clog2(OSR);

  typedef enum logic [1:0] {S_IDLE, S_START, S_SHIFT} st_t;

  st_t         st;
  logic [1:0]  sync;
  logic        rxs_d;
  logic [CW-1:0] cnt;
  logic [3:0]  idx;
  logic [9:0]  sh;

  wire       rxs      = sync[1];
  wire [3:0] nb       = (char_bits < 4'd5) ? 4'd5 : (char_bits > 4'd9) ? 4'd9 : char_bits;
  wire       nine     = (nb == 4'd9);
  wire [3:0] last_idx = nine ? 4'd9 : nb + 4'd1;
  wire [3:0] type_idx = nine ? 4'd8 : nb;
  wire [7:0] mask     = nine ? 8'hFF : (8'hFF >> (4'd8 - nb));
  wire       bit_end  = (st == S_SHIFT) && os_tick && (cnt == CW'(OSR - 1));
  wire       done     = bit_end && (idx == last_idx);
  wire       type_bit = sh[type_idx];
  wire       accept   = !filter_en || type_bit;
  wire       full     = rx_valid && !rd_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync  <= 2'b11;
      rxs_d <= 1'b1;
    end else begin
      sync  <= {sync[0], rx_in};
      rxs_d <= rxs;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      idx <= '0;
      sh  <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (rxs_d && !rxs) begin
            st  <= S_START;
            cnt <= '0;
          end
        S_START:
          if (os_tick) begin
            if (cnt == CW'(HALF - 1)) begin
              st  <= rxs ? S_IDLE : S_SHIFT;
              cnt <= '0;
              idx <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        S_SHIFT:
          if (os_tick) begin
            if (bit_end) begin
              cnt     <= '0;
              sh[idx] <= rxs;
              if (idx == last_idx) st <= S_IDLE;
              else idx <= idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_type  <= 1'b0;
      rx_valid <= 1'b0;
      rx_ferr  <= 1'b0;
      rx_ovr   <= 1'b0;
    end else begin
      if (rd_strobe) begin
        rx_valid <= 1'b0;
        rx_ovr   <= 1'b0;
      end
      if (done && accept) begin
        if (full) begin
          rx_ovr <= 1'b1;
        end else begin
          rx_data  <= sh[7:0] & mask;
          rx_type  <= type_bit;
          rx_ferr  <= !rxs;
          rx_valid <= 1'b1;
        end
      end
    end
  end

  AST_START_LOW_AT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SHIFT && $past(st) == S_START) |-> !$past(rxs)); // R1
  AST_FILTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && filter_en && !type_bit && !rd_strobe) |=>
      ($stable(rx_valid) && $stable(rx_data) && $stable(rx_ovr))); // R5
  AST_ADDR_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && type_bit && !full) |=> (rx_valid && rx_type)); // R6
  AST_OVR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && accept && full) |=> (rx_ovr && $stable(rx_data))); // R9
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !done) |=> (!rx_valid && !rx_ovr)); // R9
  AST_OVR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovr |-> rx_valid); // R9
endmodule

// File: tb/mdrop_uart_rx_bench.sv
module mdrop_uart_rx_bench;
  localparam int TPB = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_in = 1'b1;
  logic       os_tick = 1'b0;
  logic [3:0] char_bits = 4'd8;
  logic       filter_en = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [7:0] rx_data;
  logic       rx_type, rx_valid, rx_ferr, rx_ovr;

  int runs = 0, fails = 0;
  logic [7:0] m_data = '0;
  logic m_type = 0, m_valid = 0, m_ferr = 0, m_ovr = 0;
  logic [1:0] tdiv = '0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    tdiv    <= tdiv + 1'b1;
    os_tick <= (tdiv == 2'd3);
  end

  mdrop_uart_rx u_mdrop_uart_rx (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .os_tick(os_tick),
    .char_bits(char_bits), .filter_en(filter_en), .rd_strobe(rd_strobe),
    .rx_data(rx_data), .rx_type(rx_type), .rx_valid(rx_valid),
    .rx_ferr(rx_ferr), .rx_ovr(rx_ovr));

  function automatic int eff_n(input logic [3:0] c);
    if (c < 5) return 5;
    if (c > 9) return 9;
    return int'(c);
  endfunction

  function automatic logic [7:0] mask8(input int n);
    if (n >= 8) return 8'hFF;
    return (8'h1 << n) - 8'h1;
  endfunction

  task automatic line_bit(input logic b);
    rx_in = b;
    repeat (TPB) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic typ, input logic stop_ok);
    int n;
    logic acc;
    n = eff_n(char_bits);
    @(negedge clk);
    line_bit(1'b0);
    for (int i = 0; i < n && i < 8; i++) line_bit(d[i]);
    if (n == 9) begin
      line_bit(typ);
      line_bit(stop_ok);
    end else begin
      line_bit(typ);
      line_bit(stop_ok);
    end
    rx_in = 1'b1;
    repeat (2 * TPB) @(negedge clk);
    acc = !filter_en || typ;
    if (acc) begin
      if (m_valid) m_ovr = 1'b1;
      else begin
        m_data  = d & mask8(n);
        m_type  = typ;
        m_ferr  = !stop_ok;
        m_valid = 1'b1;
      end
    end
  endtask

  task automatic do_read();
    @(negedge clk);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    m_valid = 1'b0;
    m_ovr   = 1'b0;
    @(negedge clk);
  endtask

  task automatic check(input string tag);
    @(negedge clk);
    runs++;
    if (rx_valid !== m_valid || rx_data !== m_data || rx_type !== m_type ||
        rx_ferr !== m_ferr || rx_ovr !== m_ovr) begin
      fails++;
      $display("FAIL %s: got v=%b d=%h t=%b fe=%b ov=%b exp v=%b d=%h t=%b fe=%b ov=%b",
               tag, rx_valid, rx_data, rx_type, rx_ferr, rx_ovr,
               m_valid, m_data, m_type, m_ferr, m_ovr);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    check("R11");

    filter_en = 0; char_bits = 4'd8;
    send_frame(8'hA5, 1'b0, 1'b1); check("R7 R4");
    do_read(); check("R9 read");

    char_bits = 4'd9;
    send_frame(8'hC3, 1'b1, 1'b1); check("R3");
    do_read();

    char_bits = 4'd5;
    send_frame(8'hFF, 1'b1, 1'b1); check("R2 R4");
    do_read();
    char_bits = 4'd2;
    send_frame(8'hEA, 1'b0, 1'b1); check("R2 clamp");
    do_read();

    filter_en = 1; char_bits = 4'd8;
    send_frame(8'h3C, 1'b0, 1'b1); check("R5");
    char_bits = 4'd6;
    send_frame(8'h15, 1'b0, 1'b1); check("R8 R5");
    send_frame(8'h2A, 1'b1, 1'b1); check("R6");
    do_read();

    filter_en = 0; char_bits = 4'd8;
    send_frame(8'h81, 1'b1, 1'b0); check("R8");
    do_read();
    char_bits = 4'd7;
    send_frame(8'h55, 1'b0, 1'b1); check("R8 first stop");
    send_frame(8'h11, 1'b0, 1'b1); check("R9 overrun");
    do_read(); check("R9 clear");

    @(negedge clk); rx_in = 1'b0;
    repeat (12) @(negedge clk); rx_in = 1'b1;
    repeat (3 * TPB) @(negedge clk);
    check("R1 glitch");
    char_bits = 4'd8;
    send_frame(8'h69, 1'b1, 1'b1); check("R1 after glitch");
    do_read();

    filter_en = 1;
    fork
      send_frame(8'h4D, 1'b0, 1'b1);
      begin repeat (4 * TPB) @(negedge clk); filter_en = 0; end
    join
    check("R10 clear mid");
    do_read();
    fork
      send_frame(8'h72, 1'b0, 1'b1);
      begin repeat (4 * TPB) @(negedge clk); filter_en = 1; end
    join
    check("R10 set mid");

    for (int k = 0; k < 50; k++) begin
      r = $urandom;
      char_bits = 4'(5 + (r[2:0] % 5));
      filter_en = r[3];
      send_frame(r[15:8], r[4], r[7:5] != 3'd0);
      check(r[3] && !r[4] ? "R5 rnd" : (r[4] ? "R6 rnd" : "R7 rnd"));
      if (r[16]) do_read();
    end

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule